// File: doc/BRIEF.md
# Link Error Recovery Escalation Controller

This block supervises recovery on a multi-lane serial link whose traffic is checked by CRC. Each CRC failure is first answered with a retransmission request. If the number of retries reaches the programmed limit before a transaction goes through, the controller asks the physical layer to reset and retrain the link. If retries run out again after that reset, before any transaction has gone through, it decides that a lane is faulty. It maps out the part of the link that holds that lane, so the link drops from full to half width or from half to quarter width. When a quarter-width link fails once more, the link is declared down.

The link layer reports each CRC failure and each accepted transaction as one-cycle strobes. It also gives a per-lane error indicator, which the controller uses to pick the lane segment to keep. The physical layer receives a level reset request and answers with a one-cycle done strobe. The controller drives the lane-enable mask and a width code. It raises a one-cycle event for each corrected escalation and for the one uncorrected one. The retry buffer, the PHY and the CRC logic are outside this block.

Top module: `link_recovery_ctrl`

## Requirements
- R1: A `crc_err` strobe seen while the retry count is below `retry_limit` gives a one-cycle `retry_req` pulse in the next cycle and raises the count by one.
- R2: An `xfer_ok` strobe clears the retry count and the after-reset flag. When `xfer_ok` and `crc_err` come in the same cycle, the clear is applied first and the error is then judged against a count of zero.
- R3: A `crc_err` seen with the count equal to `retry_limit`, and with no reset since the last successful transaction, raises `phy_rst_req` and gives a one-cycle `corr_evt` in the next cycle. The count is cleared.
- R4: `phy_rst_req` stays high until `phy_rst_done` is seen. The controller then returns to traffic with the after-reset flag set. A `phy_rst_done` that comes while no reset is pending has no effect.
- R5: Once the after-reset flag is set, exhausting the retries again maps out a lane segment. The controller enters reset and gives a `corr_evt`.
- R6: A map-out halves the active segment. The `width_code` goes from 0 (full, all LANES lanes) to 1 (half, LANES/2 lanes) to 2 (quarter, LANES/4 lanes). The lower sub-segment is dropped when the lowest enabled lane flagged in `lane_err` lies inside it. Otherwise the lower sub-segment is kept.
- R7: `lane_en` changes only in cycles where `phy_rst_req` is high.
- R8: If no `phy_rst_done` comes within RST_TMO cycles of the reset starting, the controller maps out a segment while still in reset, restarts the wait and gives a `corr_evt`.
- R9: A map-out attempted at quarter width instead sets `link_down`, which stays set. It gives a one-cycle `uncorr_evt`, drops `phy_rst_req`, sets `width_code` to 3 and freezes `lane_en`. From then on all inputs are ignored.
- R10: After reset, `lane_en` is all ones, `width_code` is 0, and every strobe as well as `phy_rst_req` and `link_down` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retry_limit | input | CNT_W | Number of retries allowed before escalation |
| crc_err | input | 1 | One-cycle strobe: CRC failure on a received transaction |
| xfer_ok | input | 1 | One-cycle strobe: a transaction was accepted |
| lane_err | input | LANES | Per-lane error indicator |
| phy_rst_done | input | 1 | One-cycle strobe: link reset and retraining finished |
| phy_rst_req | output | 1 | Level request for a link reset |
| retry_req | output | 1 | One-cycle retransmission request |
| corr_evt | output | 1 | One-cycle corrected-error escalation event |
| uncorr_evt | output | 1 | One-cycle uncorrected event when the link goes down |
| link_down | output | 1 | Sticky fatal status |
| width_code | output | 2 | 0 full, 1 half, 2 quarter, 3 down |
| lane_en | output | LANES | Lane-enable mask |

## Verification
Two pairs of events can land in the same cycle. The first is an accepted transaction with a CRC failure. The second is the reset-done strobe with the last cycle of the reset timeout window. The bench drives `xfer_ok` and `crc_err` together, both when the count is already at the limit and right after a reset. A correct design then answers with a plain retry, not an escalation. A behavioural model run beside the design makes the same decision on every clock and compares every output. It also lets a reset wait expire and checks that the map-out happens during that same reset.

// File: rtl/lrec_pkg.sv
// Shared types for the link recovery controller.
// Assumes: width codes are ordered so that degradation only increases them.
package lrec_pkg;
    typedef enum logic [1:0] {
        W_FULL = 2'd0,
        W_HALF = 2'd1,
        W_QTR  = 2'd2,
        W_DOWN = 2'd3
    } width_t;

    typedef enum logic [1:0] {
        S_RUN  = 2'd0,
        S_RST  = 2'd1,
        S_DOWN = 2'd2
    } rec_state_t;
endpackage

// File: rtl/lrec_retry_ctr.sv
// Retry counter: clears on request, then adds one when asked.
// Assumes: the caller never increments past the programmed limit.
module lrec_retry_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    // Count update: the clear applies before the increment in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= (clr ? '0 : cnt) + {{(CNT_W-1){1'b0}}, inc};
    end
endmodule

// File: rtl/lrec_rst_timer.sv
// Reset watchdog: counts cycles spent in reset; flags the last cycle of the window.
// Assumes: run is high exactly while a reset is pending.
module lrec_rst_timer #(
    parameter int RST_TMO = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int TW = (RST_TMO > 1) ? $clog2(RST_TMO) : 1;
    localparam logic [TW-1:0] LAST = TW'(RST_TMO - 1);

    logic [TW-1:0] tcnt;

    // Cycle counter: held at zero outside reset and on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) tcnt <= '0;
        else                           tcnt <= tcnt + 1'b1;
    end

    assign expired = run && (tcnt == LAST);
endmodule

// File: rtl/lrec_lane_plan.sv
// Map-out planner: picks the sub-segment to keep after halving the active segment.
// Assumes: LANES divisible by 4; width is full or half when the result is used.
module lrec_lane_plan
    import lrec_pkg::*;
#(
    parameter int LANES = 20,
    parameter int BW    = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] lane_err,
    input  logic [LANES-1:0] lane_en,
    input  logic [BW-1:0]    base,
    input  width_t           width,
    output logic [BW-1:0]    nxt_base
);
    localparam int HALF = LANES / 2;
    localparam int QTR  = LANES / 4;

    // Lowest enabled flagged lane, then keep the sub-segment that avoids it.
    always_comb begin
        int newsize;
        int bad;
        logic found;
        newsize = (width == W_FULL) ? HALF : QTR;
        bad     = 0;
        found   = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (lane_err[i] && lane_en[i]) begin
                bad   = i;
                found = 1'b1;
            end
        end
        if (found && (bad < int'(base) + newsize))
            nxt_base = BW'(int'(base) + newsize);
        else
            nxt_base = base;
    end
endmodule

// File: rtl/lrec_lane_mask.sv
// Mask builder: enables the contiguous lanes of the active segment.
// Assumes: base plus segment size never exceeds LANES.
module lrec_lane_mask
    import lrec_pkg::*;
#(
    parameter int LANES = 20,
    parameter int BW    = $clog2(LANES + 1)
) (
    input  logic [BW-1:0]    base,
    input  width_t           width,
    output logic [LANES-1:0] mask
);
    logic [BW:0] lim;

    // Segment end from the width code.
    always_comb begin
        case (width)
            W_FULL:  lim = (BW+1)'(int'(base) + LANES);
            W_HALF:  lim = (BW+1)'(int'(base) + LANES / 2);
            default: lim = (BW+1)'(int'(base) + LANES / 4);
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = (i >= int'(base)) && (i < int'(lim));
    end
endmodule

// File: rtl/link_recovery_ctrl.sv
// Link recovery escalation controller: retry, then link reset, then lane map-out,
// then link down. Assumes single-cycle strobes and registered outputs.
module link_recovery_ctrl
    import lrec_pkg::*;
#(
    parameter int LANES   = 20,
    parameter int CNT_W   = 4,
    parameter int RST_TMO = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] retry_limit,
    input  logic             crc_err,
    input  logic             xfer_ok,
    input  logic [LANES-1:0] lane_err,
    input  logic             phy_rst_done,
    output logic             phy_rst_req,
    output logic             retry_req,
    output logic             corr_evt,
    output logic             uncorr_evt,
    output logic             link_down,
    output logic [1:0]       width_code,
    output logic [LANES-1:0] lane_en
);
    localparam int BW = $clog2(LANES + 1);

    rec_state_t       state, n_state;
    width_t           width, n_width;
    logic [BW-1:0]    base, n_base, plan_base;
    logic             after_rst, n_after;
    logic             n_retry, n_corr, n_uncorr;
    logic             ctr_clr, ctr_inc, t_restart, t_exp, escalate;
    logic [CNT_W-1:0] cnt, eff_cnt;
    logic             eff_after;

    lrec_retry_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .inc(ctr_inc), .cnt(cnt)
    );

    lrec_rst_timer #(.RST_TMO(RST_TMO)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(state == S_RST),
        .restart(t_restart), .expired(t_exp)
    );

    lrec_lane_plan #(.LANES(LANES), .BW(BW)) u_plan (
        .lane_err(lane_err), .lane_en(lane_en), .base(base),
        .width(width), .nxt_base(plan_base)
    );

    lrec_lane_mask #(.LANES(LANES), .BW(BW)) u_mask (
        .base(base), .width(width), .mask(lane_en)
    );

    // Recovery decision for the current cycle.
    always_comb begin
        n_state   = state;
        n_width   = width;
        n_base    = base;
        n_after   = after_rst;
        n_retry   = 1'b0;
        n_corr    = 1'b0;
        n_uncorr  = 1'b0;
        ctr_clr   = 1'b0;
        ctr_inc   = 1'b0;
        t_restart = 1'b0;
        escalate  = 1'b0;
        eff_cnt   = xfer_ok ? '0 : cnt;
        eff_after = xfer_ok ? 1'b0 : after_rst;
        case (state)
            S_RUN: begin
                ctr_clr = xfer_ok;
                n_after = eff_after;
                if (crc_err) begin
                    if (eff_cnt < retry_limit) begin
                        ctr_inc = 1'b1;
                        n_retry = 1'b1;
                    end else begin
                        ctr_clr = 1'b1;
                        if (!eff_after) begin
                            n_state = S_RST;
                            n_corr  = 1'b1;
                        end else begin
                            escalate = 1'b1;
                        end
                    end
                end
            end
            S_RST: begin
                if (phy_rst_done) begin
                    n_state   = S_RUN;
                    n_after   = 1'b1;
                    t_restart = 1'b1;
                end else if (t_exp) begin
                    escalate  = 1'b1;
                    t_restart = 1'b1;
                end
            end
            default: ;
        endcase
        if (escalate) begin
            if (width == W_QTR) begin
                n_state  = S_DOWN;
                n_uncorr = 1'b1;
            end else begin
                n_state = S_RST;
                n_width = width_t'(width + 2'd1);
                n_base  = plan_base;
                n_corr  = 1'b1;
            end
        end
    end

    // State, segment and event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_RUN;
            width      <= W_FULL;
            base       <= '0;
            after_rst  <= 1'b0;
            retry_req  <= 1'b0;
            corr_evt   <= 1'b0;
            uncorr_evt <= 1'b0;
        end else begin
            state      <= n_state;
            width      <= n_width;
            base       <= n_base;
            after_rst  <= n_after;
            retry_req  <= n_retry;
            corr_evt   <= n_corr;
            uncorr_evt <= n_uncorr;
        end
    end

    assign phy_rst_req = (state == S_RST);
    assign link_down   = (state == S_DOWN);
    assign width_code  = link_down ? W_DOWN : width;
endmodule

// File: rtl/lrec_chk.sv
// Checker for the link recovery controller, attached by bind.
// Assumes: reset is held low from time zero for at least one clock.
module lrec_chk #(
    parameter int LANES = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phy_rst_req,
    input logic             retry_req,
    input logic             corr_evt,
    input logic             uncorr_evt,
    input logic             link_down,
    input logic [1:0]       width_code,
    input logic [LANES-1:0] lane_en
);
    // R7
    mask_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lane_en) |-> phy_rst_req);

    // R1
    retry_not_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |-> !phy_rst_req && !corr_evt);

    // R9
    down_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_down |=> link_down);

    // R9
    down_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_down) |-> uncorr_evt && !phy_rst_req);

    // R6
    width_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> width_code >= $past(width_code));

    // R6
    mask_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (width_code != 2'd3) |->
            ($countones(lane_en) == (LANES >> width_code)));
endmodule

bind link_recovery_ctrl lrec_chk #(.LANES(LANES)) u_lrec_chk (
    .clk(clk), .rst_n(rst_n), .phy_rst_req(phy_rst_req), .retry_req(retry_req),
    .corr_evt(corr_evt), .uncorr_evt(uncorr_evt), .link_down(link_down),
    .width_code(width_code), .lane_en(lane_en)
);

// File: tb/link_recovery_ctrl_bench.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module link_recovery_ctrl_bench;
    localparam int LANES = 20;
    localparam int CNT_W = 4;
    localparam int TMO   = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] retry_limit = 4'd2;
    logic             crc_err = 1'b0, xfer_ok = 1'b0, phy_rst_done = 1'b0;
    logic [LANES-1:0] lane_err = '0;
    logic             phy_rst_req, retry_req, corr_evt, uncorr_evt, link_down;
    logic [1:0]       width_code;
    logic [LANES-1:0] lane_en;

    int n_chk = 0, n_bad = 0, cycles = 0;

    link_recovery_ctrl #(.LANES(LANES), .CNT_W(CNT_W), .RST_TMO(TMO)) u_link_recovery_ctrl (
        .clk(clk), .rst_n(rst_n), .retry_limit(retry_limit), .crc_err(crc_err),
        .xfer_ok(xfer_ok), .lane_err(lane_err), .phy_rst_done(phy_rst_done),
        .phy_rst_req(phy_rst_req), .retry_req(retry_req), .corr_evt(corr_evt),
        .uncorr_evt(uncorr_evt), .link_down(link_down), .width_code(width_code),
        .lane_en(lane_en)
    );

    always #2 clk = ~clk;

    // Reference model state
    int m_cnt, m_width, m_base, m_tmr;
    bit m_after, m_rst, m_down, m_retry, m_corr, m_uncorr;

    function automatic logic [LANES-1:0] seg_mask(int b, int w);
        logic [LANES-1:0] m = '0;
        int sz = LANES >> w;
        for (int i = 0; i < LANES; i++) if (i >= b && i < b + sz) m[i] = 1'b1;
        return m;
    endfunction

    task automatic m_fail_step();
        if (m_width == 2) begin
            m_down = 1; m_rst = 0; m_uncorr = 1;
        end else begin
            int sz = LANES >> (m_width + 1);
            int bad = -1;
            logic [LANES-1:0] cur = seg_mask(m_base, m_width);
            for (int i = LANES - 1; i >= 0; i--) if (lane_err[i] && cur[i]) bad = i;
            if (bad >= 0 && bad < m_base + sz) m_base = m_base + sz;
            m_width++; m_corr = 1; m_rst = 1;
        end
    endtask

    always @(posedge clk) begin
        m_retry = 0; m_corr = 0; m_uncorr = 0;
        if (!rst_n) begin
            m_cnt = 0; m_width = 0; m_base = 0; m_tmr = 0;
            m_after = 0; m_rst = 0; m_down = 0;
        end else if (m_down) begin
        end else if (m_rst) begin
            if (phy_rst_done) begin m_rst = 0; m_after = 1; m_tmr = 0; end
            else if (m_tmr == TMO - 1) begin m_fail_step(); m_tmr = 0; end
            else m_tmr++;
        end else begin
            if (xfer_ok) begin m_cnt = 0; m_after = 0; end
            if (crc_err) begin
                if (m_cnt < int'(retry_limit)) begin m_cnt++; m_retry = 1; end
                else begin
                    m_cnt = 0;
                    if (!m_after) begin m_rst = 1; m_tmr = 0; m_corr = 1; end
                    else begin m_fail_step(); m_tmr = 0; end
                end
            end
        end
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [LANES-1:0] prev_en;
    bit               have_prev = 0;

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(retry_req == m_retry, "R1", "retry_req", retry_req, m_retry);
            check(corr_evt == m_corr, "R3", "corr_evt", corr_evt, m_corr);
            check(phy_rst_req == m_rst, "R4", "phy_rst_req", phy_rst_req, m_rst);
            check(uncorr_evt == m_uncorr, "R9", "uncorr_evt", uncorr_evt, m_uncorr);
            check(link_down == m_down, "R9", "link_down", link_down, m_down);
            check(width_code == (m_down ? 2'd3 : 2'(m_width)), "R6", "width_code",
                  width_code, m_down ? 3 : m_width);
            check(lane_en == seg_mask(m_base, m_width), "R6", "lane_en",
                  lane_en, seg_mask(m_base, m_width));
            if (have_prev && lane_en != prev_en)
                check(phy_rst_req, "R7", "mask change outside reset", phy_rst_req, 1);
            prev_en = lane_en; have_prev = 1;
        end
    end

    task automatic pulse(bit c, bit x, bit d, logic [LANES-1:0] le);
        @(negedge clk);
        crc_err = c; xfer_ok = x; phy_rst_done = d; lane_err = le;
        @(negedge clk);
        crc_err = 0; xfer_ok = 0; phy_rst_done = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1;
        // R10 reset state
        check(lane_en == '1 && width_code == 0, "R10", "mask/width", lane_en, '1);
        check(!phy_rst_req && !link_down && !retry_req && !corr_evt, "R10", "status",
              {phy_rst_req, link_down, retry_req, corr_evt}, 0);
        // R1 retries, R2 success clears the count
        pulse(1, 0, 0, '0); pulse(1, 0, 0, '0);
        pulse(0, 1, 0, '0);
        pulse(1, 0, 0, '0); pulse(1, 0, 0, '0);
        // R2: count at limit, success and error together -> still a retry
        @(negedge clk); crc_err = 1; xfer_ok = 1;
        @(negedge clk); crc_err = 0; xfer_ok = 0;
        check(retry_req && !phy_rst_req, "R2", "same-cycle retry", retry_req, 1);
        // R3 escalate to reset
        pulse(1, 0, 0, '0); pulse(1, 0, 0, '0);
        check(phy_rst_req, "R3", "reset after exhausted retries", phy_rst_req, 1);
        idle(5);
        check(phy_rst_req, "R4", "reset held until done", phy_rst_req, 1);
        pulse(0, 0, 1, '0);
        check(!phy_rst_req, "R4", "reset released", phy_rst_req, 0);
        // R4 stray done ignored
        pulse(0, 0, 1, '0);
        check(!phy_rst_req && !corr_evt, "R4", "stray done", phy_rst_req, 0);
        // R2: success with error right after reset -> retry, after-reset cleared
        @(negedge clk); crc_err = 1; xfer_ok = 1;
        @(negedge clk); crc_err = 0; xfer_ok = 0;
        check(retry_req, "R2", "retry after reset with success", retry_req, 1);
        pulse(1, 0, 0, '0); pulse(1, 0, 0, '0);
        check(phy_rst_req && width_code == 0, "R3", "plain reset again", width_code, 0);
        pulse(0, 0, 1, '0);
        // R5 persistent error after reset: lane 3 flagged -> keep upper half
        pulse(1, 0, 0, '0); pulse(1, 0, 0, '0); pulse(1, 0, 0, 20'h00008);
        check(width_code == 1 && lane_en == 20'hFFC00, "R5", "map-out to half",
              lane_en, 20'hFFC00);
        // R8 timeout: lane 12 flagged -> keep lanes 15..19
        @(negedge clk); lane_err = 20'h01000;
        idle(70);
        check(width_code == 2 && lane_en == 20'hF8000 && phy_rst_req, "R8",
              "timeout map-out", lane_en, 20'hF8000);
        lane_err = '0;
        pulse(0, 0, 1, '0);
        // R9 failure at quarter width
        pulse(1, 0, 0, '0); pulse(1, 0, 0, '0); pulse(1, 0, 0, '0);
        check(link_down && width_code == 3 && !phy_rst_req, "R9", "link down",
              width_code, 3);
        pulse(1, 1, 1, '1); idle(3);
        check(link_down && lane_en == 20'hF8000 && !retry_req, "R9", "inputs ignored",
              lane_en, 20'hF8000);
        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule